// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is the read-only slave end of an I2C bus. It watches SCL and SDA, spots START and STOP conditions, and checks whether an incoming address byte carries its own 7-bit address with the read bit set. When it is selected it returns ACK. It then shifts out bytes that a local host has placed in a data register. It never drives either line high. It only pulls SCL or SDA low, and the external wiring forms the wired-AND bus.

Every bus event ends with an 8-bit status code and a raised interrupt flag. While the flag is up, the slave holds SCL low. The host reads the code, loads the next byte, and writes one to the flag, which releases the clock and lets the transfer continue. When the flag is clear, the status register shows a "no information" value.

A START or STOP that arrives inside an address bit, data bit or acknowledge slot is a bus error. The host leaves that state by writing the stop bit together with the flag clear. The block then drops back to the not-addressed state and drives nothing on the bus while doing so.

Top module: `i2c_slv_tx`

## Requirements
- R1: After reset:
  - the status reads 0xF8;
  - the interrupt flag, the stop bit and the enable-acknowledge bit are 0;
  - neither SCL nor SDA is pulled low.
- R2: An address byte that matches `own_addr_i` in bits 7..1 and has bit 0 = 1 (read) is acknowledged while enable-acknowledge is 1. The slave pulls SDA low during the ninth clock. After that clock falls, the flag is set and the status reads 0xA8.
- R3: An address byte is left unacknowledged when its address differs, its bit 0 is 0 (write), or enable-acknowledge is 0. No flag is raised and the status stays 0xF8.
- R4: While the flag is set, SCL is held low. After the host writes one to the flag, SCL is held for one more cycle and then released.
- R5: The data byte is taken from the data register at the moment the flag is cleared. It is sent MSB first.
- R6: A byte that the master ACKs while enable-acknowledge was 1 at load time gives status 0xB8 with the flag set. The next byte follows.
- R7: A byte that the master NACKs gives status 0xC0 with the flag set. The slave is then not addressed.
- R8: A byte loaded with enable-acknowledge 0 and then ACKed gives status 0xC8. The slave is then not addressed, and every further bit read from it is 1.
- R9: Whenever the flag is clear, the status reads 0xF8.
- R10: A START or STOP during address bits, data bits or an acknowledge slot sets the flag with status 0x00.
- R11: In the bus-error state, writing the stop bit and one to the flag clears the flag, clears the stop bit and releases SCL and SDA. The slave returns to not addressed, and enable-acknowledge keeps the value written.
- R12: In the bus-error state, writing one to the flag without the stop bit has no effect. The flag stays set and the status stays 0x00.
- R13: SDA is only pulled or released while SCL is low. The slave never drives a line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| own_addr_i | input | 7 | Slave address to match |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_pull_o | output | 1 | 1 pulls SCL low |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| data_we_i | input | 1 | Write strobe for the data register |
| data_i | input | 8 | Next byte to transmit |
| ctrl_we_i | input | 1 | Write strobe for the control bits |
| ctrl_ea_i | input | 1 | Enable-acknowledge value to write |
| ctrl_sto_i | input | 1 | Stop bit value to write |
| ctrl_int_i | input | 1 | Write 1 to clear the interrupt flag |
| int_o | output | 1 | Interrupt flag |
| ea_o | output | 1 | Enable-acknowledge bit |
| sto_o | output | 1 | Stop bit |
| status_o | output | 8 | Status code |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and own address 0x5A. The deeper synchronizer delays every detected edge, start and stop by one extra cycle. That tests whether the SCL hold after a flag clear still lets the first data bit settle before the clock rises, and whether the slave changes SDA only inside SCL-low windows.

A bus model ANDs the master's lines with the slave's pull-downs. This lets stretching, acknowledges and the all-ones reads after the final byte be seen as real line levels.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_TX,
    S_DATA_ACK,
    S_ERR
  } slv_state_e;

  localparam logic [7:0] ST_ADDR_ACK  = 8'hA8;
  localparam logic [7:0] ST_DATA_ACK  = 8'hB8;
  localparam logic [7:0] ST_DATA_NACK = 8'hC0;
  localparam logic [7:0] ST_LAST_ACK  = 8'hC8;
  localparam logic [7:0] ST_NO_INFO   = 8'hF8;
  localparam logic [7:0] ST_BUS_ERR   = 8'h00;
  // reserved: addressed after lost arbitration, never produced here
  localparam logic [7:0] ST_ARB_ADDR  = 8'hB0;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] pipe_q;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], line_i};
  end

  assign line_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_ea_i,
  input  logic              ctrl_sto_i,
  input  logic              ctrl_int_i,
  input  logic              evt_i,
  input  logic [7:0]        code_i,
  input  logic              in_err_i,
  output logic [DATA_W-1:0] data_nx_o,
  output logic              ea_nx_o,
  output logic              release_o,
  output logic              recover_o,
  output logic              stretch_o,
  output logic              int_o,
  output logic              ea_o,
  output logic              sto_o,
  output logic [7:0]        status_o
);
  logic [DATA_W-1:0] data_q;
  logic              ea_q, sto_q, int_q, rel_q;
  logic [7:0]        code_q;
  logic              clr_req;

  assign clr_req   = ctrl_we_i & ctrl_int_i & int_q;
  assign recover_o = clr_req & ctrl_sto_i & in_err_i;
  assign release_o = clr_req & ~in_err_i;
  assign data_nx_o = data_we_i ? data_i : data_q;
  assign ea_nx_o   = ctrl_we_i ? ctrl_ea_i : ea_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ea_q   <= 1'b0;
      sto_q  <= 1'b0;
      int_q  <= 1'b0;
      rel_q  <= 1'b0;
      code_q <= ST_NO_INFO;
    end else begin
      data_q <= data_nx_o;
      ea_q   <= ea_nx_o;
      rel_q  <= release_o;
      if (ctrl_we_i) sto_q <= ctrl_sto_i & ~recover_o;
      if (evt_i) begin
        int_q  <= 1'b1;
        code_q <= code_i;
      end else if (release_o || recover_o) begin
        int_q  <= 1'b0;
      end
    end
  end

  // hold SCL one extra cycle so the first data bit settles before release
  assign stretch_o = int_q | rel_q;
  assign int_o     = int_q;
  assign ea_o      = ea_q;
  assign sto_o     = sto_q;
  assign status_o  = int_q ? code_q : ST_NO_INFO;

  // R12
  err_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_err_i && int_q && ctrl_we_i && ctrl_int_i && !ctrl_sto_i) |=> int_q);

  // R11
  recover_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |=> (!int_q && !sto_q && status_o == ST_NO_INFO));

  // R10
  bus_err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && code_i == ST_BUS_ERR) |=> (int_q && status_o == ST_BUS_ERR));

  // R4
  stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> (stretch_o && !int_q));
endmodule

// File: rtl/i2c_slv_tx_fsm.sv
module i2c_slv_tx_fsm
  import i2c_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ea_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              release_i,
  input  logic              recover_i,
  output logic              evt_o,
  output logic [7:0]        code_o,
  output logic              sda_pull_o,
  output logic              in_err_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              tx_q, last_q, ack_q, evt_q;
  logic [7:0]        code_q;
  logic              in_slot, addr_hit;

  assign in_slot = (state_q == S_ADDR && cnt_q != '0) || state_q == S_ADDR_ACK ||
                   state_q == S_TX || state_q == S_DATA_ACK;
  assign addr_hit = (shreg_q[DATA_W-1:1] == own_addr_i) && shreg_q[0] && ea_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      shreg_q <= '1;
      tx_q    <= 1'b0;
      last_q  <= 1'b0;
      ack_q   <= 1'b0;
      evt_q   <= 1'b0;
      code_q  <= ST_NO_INFO;
    end else begin
      evt_q <= 1'b0;
      if (recover_i) begin
        state_q <= S_IDLE;
        tx_q    <= 1'b0;
      end else if ((start_i || stop_i) && in_slot) begin
        state_q <= S_ERR;
        tx_q    <= 1'b0;
        evt_q   <= 1'b1;
        code_q  <= ST_BUS_ERR;
      end else begin
        case (state_q)
          S_IDLE: if (start_i) begin
            state_q <= S_ADDR;
            cnt_q   <= '0;
          end
          S_ADDR: begin
            if (start_i) cnt_q <= '0;
            else if (stop_i) state_q <= S_IDLE;
            else if (scl_rise_i && cnt_q != CNT_FULL) begin
              shreg_q <= {shreg_q[DATA_W-2:0], sda_lvl_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              state_q <= addr_hit ? S_ADDR_ACK : S_IDLE;
            end
          end
          S_ADDR_ACK: if (scl_fall_i) begin
            state_q <= S_TX;
            cnt_q   <= '0;
            evt_q   <= 1'b1;
            code_q  <= ST_ADDR_ACK;
          end
          S_TX: begin
            if (release_i) begin
              shreg_q <= data_i;
              tx_q    <= 1'b1;
              last_q  <= ~ea_i;
            end else if (scl_fall_i && tx_q) begin
              shreg_q <= {shreg_q[DATA_W-2:0], 1'b1};
              if (cnt_q == CNT_LAST) begin
                state_q <= S_DATA_ACK;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          S_DATA_ACK: begin
            if (scl_rise_i) ack_q <= ~sda_lvl_i;
            else if (scl_fall_i) begin
              tx_q  <= 1'b0;
              evt_q <= 1'b1;
              if (!ack_q) begin
                code_q  <= ST_DATA_NACK;
                state_q <= S_IDLE;
              end else if (last_q) begin
                code_q  <= ST_LAST_ACK;
                state_q <= S_IDLE;
              end else begin
                code_q  <= ST_DATA_ACK;
                state_q <= S_TX;
              end
            end
          end
          S_ERR: ;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_o = (state_q == S_ADDR_ACK) ||
                      (state_q == S_TX && tx_q && !shreg_q[DATA_W-1]);
  assign evt_o    = evt_q;
  assign code_o   = code_q;
  assign in_err_o = (state_q == S_ERR);

  // R13
  sda_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_lvl_i);

  // R7
  not_addr_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && (code_o == ST_DATA_NACK || code_o == ST_LAST_ACK)) |-> state_q == S_IDLE);

  // R2
  evt_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(scl_fall_i || start_i || stop_i));
endmodule

// File: rtl/i2c_slv_tx.sv
module i2c_slv_tx
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_ea_i,
  input  logic              ctrl_sto_i,
  input  logic              ctrl_int_i,
  output logic              int_o,
  output logic              ea_o,
  output logic              sto_o,
  output logic [7:0]        status_o
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] raw, synced;
  logic scl_rise, scl_fall, start, stop;
  logic evt, in_err, release_p, recover_p, ea_nx;
  logic [7:0] code;
  logic [DATA_W-1:0] data_nx;

  assign raw = {sda_i, scl_i};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[i]),
      .line_o (synced[i])
    );
  end

  i2c_bus_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (synced[0]),
    .sda_i      (synced[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_slv_tx_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .own_addr_i (own_addr_i),
    .scl_lvl_i  (synced[0]),
    .sda_lvl_i  (synced[1]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .ea_i       (ea_nx),
    .data_i     (data_nx),
    .release_i  (release_p),
    .recover_i  (recover_p),
    .evt_o      (evt),
    .code_o     (code),
    .sda_pull_o (sda_pull_o),
    .in_err_o   (in_err)
  );

  i2c_host_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_we_i  (data_we_i),
    .data_i     (data_i),
    .ctrl_we_i  (ctrl_we_i),
    .ctrl_ea_i  (ctrl_ea_i),
    .ctrl_sto_i (ctrl_sto_i),
    .ctrl_int_i (ctrl_int_i),
    .evt_i      (evt),
    .code_i     (code),
    .in_err_i   (in_err),
    .data_nx_o  (data_nx),
    .ea_nx_o    (ea_nx),
    .release_o  (release_p),
    .recover_o  (recover_p),
    .stretch_o  (scl_pull_o),
    .int_o      (int_o),
    .ea_o       (ea_o),
    .sto_o      (sto_o),
    .status_o   (status_o)
  );
endmodule

// File: tb/tb_i2c_slv_tx.sv
`timescale 1ns/1ps
module tb_i2c_slv_tx;
  localparam int H = 12;

  typedef struct packed {
    logic [7:0] abyte;
    logic       ea;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  // own address 0x5A: read byte 0xB5, write byte 0xB4
  localparam vec_t VECS [5] = '{
    '{8'hB5, 1'b1, 8'hA5, 8'hA8},
    '{8'hB4, 1'b1, 8'h11, 8'hF8},
    '{8'hB7, 1'b1, 8'h22, 8'hF8},
    '{8'hB5, 1'b0, 8'h33, 8'hF8},
    '{8'hB5, 1'b1, 8'h3C, 8'hA8}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull;
  logic data_we = 1'b0, ctrl_we = 1'b0, c_ea = 1'b0, c_sto = 1'b0, c_int = 1'b0;
  logic [7:0] data_v = '0;
  logic int_f, ea_f, sto_f;
  logic [7:0] status;
  logic scl_bus, sda_bus;

  assign scl_bus = scl_m & ~scl_pull;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_slv_tx #(.SYNC_STAGES(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(7'h5A),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .data_we_i(data_we), .data_i(data_v), .ctrl_we_i(ctrl_we), .ctrl_ea_i(c_ea),
    .ctrl_sto_i(c_sto), .ctrl_int_i(c_int), .int_o(int_f), .ea_o(ea_f),
    .sto_o(sto_f), .status_o(status)
  );

  int checks = 0, fails = 0, cyc = 0, r13_bad = 0;
  logic prev_pull = 1'b0, prev_scl = 1'b1;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && sda_pull != prev_pull && prev_scl && scl_bus) r13_bad++;
    prev_pull = sda_pull;
    prev_scl  = scl_bus;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hi();
    for (int g = 0; g < 4000 && !scl_bus; g++) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic stop_c();
    scl_m = 1'b0; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wait_hi(); wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wt(H);
    scl_m = 1'b1; wait_hi(); wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wait_hi(); wt(H/2);
    b = sda_bus; wt(H/2);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) bit_out(v[k]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      bit_in(b);
      v[k] = b;
    end
  endtask

  task automatic host_data(input logic [7:0] d);
    @(negedge clk); data_we = 1'b1; data_v = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic host_ctrl(input logic ea, input logic sto, input logic ic);
    @(negedge clk); ctrl_we = 1'b1; c_ea = ea; c_sto = sto; c_int = ic;
    @(negedge clk); ctrl_we = 1'b0; c_int = 1'b0; c_sto = 1'b0;
  endtask

  initial begin
    logic b;
    logic [7:0] rd;
    wt(5);
    rst_n = 1'b1;
    wt(2);
    // R1 / R9
    chk("R1", "status", status, 8'hF8);
    chk("R1", "flag/sto/ea", {int_f, sto_f, ea_f}, 3'b000);
    chk("R1", "pulls", {scl_pull, sda_pull}, 2'b00);

    // vector walk: address phase R2/R3, then a one-byte read closed by NACK
    for (int i = 0; i < 5; i++) begin
      host_ctrl(VECS[i].ea, 1'b0, 1'b0);
      host_data(VECS[i].data);
      start_c();
      send_byte(VECS[i].abyte);
      bit_in(b);
      chk(VECS[i].exp == 8'hA8 ? "R2" : "R3", "ack bit", b, VECS[i].exp == 8'hA8 ? 1'b0 : 1'b1);
      chk(VECS[i].exp == 8'hA8 ? "R2" : "R3", "status", status, VECS[i].exp);
      if (VECS[i].exp == 8'hA8) begin
        host_ctrl(VECS[i].ea, 1'b0, 1'b1);
        read_byte(rd);
        chk("R5", "byte", rd, VECS[i].data);
        bit_out(1'b1);
        chk("R7", "status after nack", {int_f, status}, {1'b1, 8'hC0});
        host_ctrl(VECS[i].ea, 1'b0, 1'b1);
        chk("R9", "status flag clear", status, 8'hF8);
      end
      stop_c();
      chk("R9", "status after stop", {int_f, status}, {1'b0, 8'hF8});
    end

    // multi-byte read with stretching, last-byte marking and all-ones tail
    host_ctrl(1'b1, 1'b0, 1'b0);
    start_c();
    send_byte(8'hB5);
    bit_in(b);
    chk("R2", "status", status, 8'hA8);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    chk("R4", "scl held while flag", scl_bus, 1'b0);
    host_data(8'h81);
    host_ctrl(1'b1, 1'b0, 1'b1);
    chk("R4", "scl held one cycle after clear", scl_bus, 1'b0);
    wait_hi();
    chk("R4", "scl released", scl_bus, 1'b1);
    wt(H/2);
    rd[7] = sda_bus;
    wt(H/2); scl_m = 1'b0; wt(H);
    for (int k = 6; k >= 0; k--) begin
      bit_in(b);
      rd[k] = b;
    end
    chk("R5", "msb-first byte", rd, 8'h81);
    bit_out(1'b0);
    chk("R6", "status after ack", {int_f, status}, {1'b1, 8'hB8});
    host_data(8'h7E);
    host_ctrl(1'b0, 1'b0, 1'b1);
    read_byte(rd);
    chk("R5", "second byte", rd, 8'h7E);
    bit_out(1'b0);
    chk("R8", "status last ack", {int_f, status}, {1'b1, 8'hC8});
    host_ctrl(1'b0, 1'b0, 1'b1);
    read_byte(rd);
    chk("R8", "bits after last", rd, 8'hFF);
    chk("R8", "no flag after last", {int_f, status}, {1'b0, 8'hF8});
    bit_out(1'b1);
    stop_c();

    // bus error: START inside the address byte
    host_ctrl(1'b1, 1'b0, 1'b0);
    start_c();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    chk("R10", "start in address", {int_f, status}, {1'b1, 8'h00});
    scl_m = 1'b0; wt(H);
    host_ctrl(1'b1, 1'b0, 1'b1);
    wt(2);
    chk("R12", "clear without stop", {int_f, status}, {1'b1, 8'h00});
    host_ctrl(1'b1, 1'b1, 1'b1);
    wt(2);
    chk("R11", "recovery flag/sto/ea", {int_f, sto_f, ea_f}, 3'b001);
    chk("R11", "recovery lines", {scl_pull, sda_pull, status}, {2'b00, 8'hF8});
    stop_c();
    start_c();
    send_byte(8'hB5);
    bit_in(b);
    chk("R11", "addressed after recovery", {b, status}, {1'b0, 8'hA8});
    host_ctrl(1'b1, 1'b0, 1'b1);
    read_byte(rd);
    bit_out(1'b1);
    host_ctrl(1'b1, 1'b0, 1'b1);
    stop_c();

    // bus error: STOP inside a data byte
    host_data(8'hFF);
    start_c();
    send_byte(8'hB5);
    bit_in(b);
    host_ctrl(1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) bit_in(b);
    stop_c();
    chk("R10", "stop in data", {int_f, status}, {1'b1, 8'h00});
    host_ctrl(1'b1, 1'b1, 1'b1);
    wt(2);
    chk("R11", "second recovery", {int_f, sto_f, status}, {2'b00, 8'hF8});

    chk("R13", "sda changes while scl high", r13_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule